// File: doc/BRIEF.md
# Serial PHY Control-Port Handshake Master

This block sits between a simple command interface and the register-access port of a serial PHY. That port has a 16-bit data-in bus, four request strobes and one acknowledge line. The host issues one of three commands: latch a PHY register address, write a data word, or read a data word. The block converts each command into a series of four-phase strobe handshakes. Every edge of every strobe waits until the acknowledge line reaches the same level. These checks are spaced a programmable number of cycles apart. If the acknowledge never matches within a bounded number of checks, the command ends with an error.

A write whose data word has its least significant bit set tells the PHY to reset itself. A PHY in reset cannot acknowledge, so for that write the block raises the write strobe and reports completion at once. The strobe stays high until the next command is accepted. A power-down control bit also sits in the control word. The block does not touch it; it mirrors a dedicated input.

Top module: `phy_ctlport_master`

## Requirements
- R1: After reset the four strobes, the data-in field, `busy`, `cmd_done` and `cmd_err` are all 0, and `cmd_ready` is 1.
- R2: The control word is laid out as follows. Bits 15:0 hold data-in. Bit 16 is capture-address, bit 17 is capture-data, bit 18 is write and bit 19 is read. Bit 20 is power-down and always equals the `pwr_down` input.
- R3: In the status word, bit 18 is the acknowledge and bits 15:0 hold the PHY read data.
- R4: Opcode 0 (address) puts the operand on data-in. It then raises capture-address and waits for acknowledge high, lowers it and waits for acknowledge low, then pulses `cmd_done`. With an immediate acknowledge, `cmd_done` is high in the 5th cycle after acceptance.
- R5: Opcode 1 (write) puts the operand on data-in. It runs a full capture-data handshake and then a full write-strobe handshake. With an immediate acknowledge, `cmd_done` is high in the 9th cycle.
- R6: For opcode 1 with operand bit 0 set, the block completes the capture-data handshake and raises the write strobe. It pulses `cmd_done` in the next cycle (the 6th) without checking the acknowledge. The write strobe stays high until the next command is accepted, and acceptance clears it.
- R7: Opcode 2 (read) raises the read strobe and waits for acknowledge high. At that check it latches status bits 15:0 into `rd_data`. It then lowers the strobe and waits for acknowledge low. Data-in is left unchanged.
- R8: In each wait the acknowledge is checked in the first wait cycle and then once every `POLL_CYCLES` cycles. After `RETRY_LIMIT` failed checks the command ends with `cmd_err`. For a stuck-low acknowledge on an address command, `cmd_err` is high in cycle 2+(RETRY_LIMIT-1)*POLL_CYCLES+1 after acceptance.
- R9: Whenever `cmd_err` is high, all four strobes are low.
- R10: Opcode 3 is rejected: `cmd_err` is high in the first cycle after acceptance and no strobe moves.
- R11: `cmd_ready` is high exactly when `busy` is low. `cmd_done` and `cmd_err` are single-cycle pulses that are never high together. Data-in does not change while busy.
- R12: At most one of the four strobes is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 2 | 0 address, 1 write, 2 read, 3 invalid |
| cmd_arg | input | 16 | Address or write data |
| pwr_down | input | 1 | Power-down level for control bit 20 |
| busy | output | 1 | A command is in progress |
| cmd_done | output | 1 | One-cycle pulse: command finished well |
| cmd_err | output | 1 | One-cycle pulse: timeout or invalid opcode |
| rd_data | output | 16 | Data latched by the last read |
| ctl_word | output | 21 | Control word to the PHY port |
| stat_word | input | 19 | Status word from the PHY port |

## Verification
The acknowledge model runs in five modes. In zero-delay follow, cycle counts are exact and each opcode's strobe order is recorded. In three-cycle delayed follow, the first check misses and the next succeeds, which pins down the poll spacing. In follow-but-ignore-write, the self-reset write can only finish if it skips the final wait. Stuck-low and stuck-high acknowledge separate a timeout on the rising edge from one on the falling edge, and each must land in its exact cycle with the strobes cleared. The read data on the status bus is a marker value outside the read strobe, so a latch in the wrong cycle returns the marker instead of the expected word.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_BAD   = 2'd3
  } op_e;

  localparam int DATA_W      = 16;
  localparam int NUM_STB     = 4;
  localparam int STB_LSB     = 16;
  localparam int PD_BIT      = 20;
  localparam int CTL_W       = PD_BIT + 1;
  localparam int ACK_BIT     = 18;
  localparam int STAT_W      = ACK_BIT + 1;

  localparam logic [1:0] STB_CAPA = 2'd0;
  localparam logic [1:0] STB_CAPD = 2'd1;
  localparam logic [1:0] STB_WR   = 2'd2;
  localparam logic [1:0] STB_RD   = 2'd3;

  // which strobe a step of a command moves
  function automatic logic [1:0] step_strobe(op_e op, logic [1:0] idx);
    case (op)
      OP_WRITE: return idx[1] ? STB_WR : STB_CAPD;
      OP_READ:  return STB_RD;
      default:  return STB_CAPA;
    endcase
  endfunction

  // even steps raise, odd steps lower
  function automatic logic step_level(logic [1:0] idx);
    return ~idx[0];
  endfunction

  function automatic logic [1:0] last_step(op_e op);
    return (op == OP_WRITE) ? 2'd3 : 2'd1;
  endfunction

  // self-reset write: the rising write strobe is not acknowledged
  function automatic logic skips_ack(op_e op, logic [1:0] idx, logic [DATA_W-1:0] data);
    return (op == OP_WRITE) && (idx == 2'd2) && data[0];
  endfunction

endpackage

// File: rtl/phy_poll_timer.sv
module phy_poll_timer #(
  parameter int POLL_CYCLES = 15000,
  parameter int RETRY_LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick,
  output logic give_up
);
  localparam int CW = $clog2(POLL_CYCLES + 1);
  localparam int RW = $clog2(RETRY_LIMIT + 1);

  logic [CW-1:0] cyc_q;
  logic [RW-1:0] tries_q;

  assign tick    = en && (cyc_q == '0);
  assign give_up = tick && (tries_q == RW'(RETRY_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cyc_q   <= '0;
      tries_q <= '0;
    end else if (tick) begin
      cyc_q   <= CW'(POLL_CYCLES - 1);
      tries_q <= tries_q + 1'b1;
    end else if (en && cyc_q != '0) begin
      cyc_q <= cyc_q - 1'b1;
    end
  end
endmodule

// File: rtl/phy_strobe_bank.sv
module phy_strobe_bank #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_all,
  input  logic                 set_en,
  input  logic [$clog2(N)-1:0] sel,
  input  logic                 lvl,
  output logic [N-1:0]         stb
);
  for (genvar i = 0; i < N; i++) begin : g_stb
    always_ff @(posedge clk) begin
      if (!rst_n || clr_all)
        stb[i] <= 1'b0;
      else if (set_en && sel == ($clog2(N))'(i))
        stb[i] <= lvl;
    end
  end
endmodule

// File: rtl/phy_hs_seq.sv
module phy_hs_seq
  import phy_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_arg,
  input  logic              ack,
  input  logic [DATA_W-1:0] phy_rd,
  input  logic              tick,
  input  logic              give_up,
  output logic              cmd_ready,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              tmr_clr,
  output logic              tmr_en,
  output logic              stb_clr,
  output logic              stb_set,
  output logic [1:0]        stb_sel,
  output logic              stb_lvl,
  output logic [DATA_W-1:0] data_out,
  output logic [DATA_W-1:0] rd_data,
  output logic              sample_fire,
  output logic              timeout_hit
);
  typedef enum logic [2:0] {S_IDLE, S_DRIVE, S_WAIT, S_DONE, S_FAIL} st_e;

  st_e               st_q;
  op_e               op_q;
  logic [1:0]        idx_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] rd_q;
  logic              accept, match, step_ok;

  assign accept      = (st_q == S_IDLE) && cmd_valid;
  assign stb_sel     = step_strobe(op_q, idx_q);
  assign stb_lvl     = step_level(idx_q);
  assign match       = (ack == stb_lvl);
  assign sample_fire = (st_q == S_WAIT) && tick;
  assign step_ok     = sample_fire && match;
  assign timeout_hit = sample_fire && !match && give_up;

  assign stb_clr   = accept || timeout_hit;
  assign stb_set   = (st_q == S_DRIVE);
  assign tmr_clr   = (st_q == S_DRIVE);
  assign tmr_en    = (st_q == S_WAIT);
  assign cmd_ready = (st_q == S_IDLE);
  assign busy      = (st_q != S_IDLE);
  assign done      = (st_q == S_DONE);
  assign err       = (st_q == S_FAIL);
  assign data_out  = data_q;
  assign rd_data   = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      op_q   <= OP_ADDR;
      idx_q  <= '0;
      data_q <= '0;
      rd_q   <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (cmd_valid) begin
          op_q  <= op_e'(cmd_op);
          idx_q <= '0;
          if (op_e'(cmd_op) == OP_ADDR || op_e'(cmd_op) == OP_WRITE)
            data_q <= cmd_arg;
          st_q <= (op_e'(cmd_op) == OP_BAD) ? S_FAIL : S_DRIVE;
        end
        S_DRIVE: st_q <= skips_ack(op_q, idx_q, data_q) ? S_DONE : S_WAIT;
        S_WAIT: begin
          if (step_ok) begin
            if (op_q == OP_READ && stb_lvl)
              rd_q <= phy_rd;
            if (idx_q == last_step(op_q)) begin
              st_q <= S_DONE;
            end else begin
              idx_q <= idx_q + 2'd1;
              st_q  <= S_DRIVE;
            end
          end else if (timeout_hit) begin
            st_q <= S_FAIL;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phy_ctlport_master.sv
module phy_ctlport_master
  import phy_ctl_pkg::*;
#(
  parameter int POLL_CYCLES = 15000,
  parameter int RETRY_LIMIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_arg,
  input  logic              pwr_down,
  output logic              busy,
  output logic              cmd_done,
  output logic              cmd_err,
  output logic [DATA_W-1:0] rd_data,
  output logic [CTL_W-1:0]  ctl_word,
  input  logic [STAT_W-1:0] stat_word
);
  logic              tick, give_up, tmr_clr, tmr_en;
  logic              stb_clr, stb_set, stb_lvl;
  logic [1:0]        stb_sel;
  logic [NUM_STB-1:0] stb;
  logic [DATA_W-1:0] data_in;
  logic              ack;
  logic              sample_fire, timeout_hit;
  logic              stat_unused_bits;

  assign ack              = stat_word[ACK_BIT];
  assign stat_unused_bits = ^stat_word[ACK_BIT-1:DATA_W];

  phy_poll_timer #(.POLL_CYCLES(POLL_CYCLES), .RETRY_LIMIT(RETRY_LIMIT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .en(tmr_en),
    .tick(tick), .give_up(give_up)
  );

  phy_hs_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .ack(ack), .phy_rd(stat_word[DATA_W-1:0]),
    .tick(tick), .give_up(give_up), .cmd_ready(cmd_ready), .busy(busy),
    .done(cmd_done), .err(cmd_err), .tmr_clr(tmr_clr), .tmr_en(tmr_en),
    .stb_clr(stb_clr), .stb_set(stb_set), .stb_sel(stb_sel), .stb_lvl(stb_lvl),
    .data_out(data_in), .rd_data(rd_data),
    .sample_fire(sample_fire), .timeout_hit(timeout_hit)
  );

  phy_strobe_bank #(.N(NUM_STB)) u_stb (
    .clk(clk), .rst_n(rst_n), .clr_all(stb_clr), .set_en(stb_set),
    .sel(stb_sel), .lvl(stb_lvl), .stb(stb)
  );

  assign ctl_word = {pwr_down, stb, data_in};
endmodule

// File: rtl/phy_ctlport_master_chk.sv
module phy_ctlport_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [1:0]  cmd_op,
  input logic        busy,
  input logic        cmd_done,
  input logic        cmd_err,
  input logic [20:0] ctl_word,
  input logic        sample_fire,
  input logic        timeout_hit
);
  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl_word[19:16])); // R12
  AST_ERR_STB_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> ctl_word[19:16] == 4'd0); // R9
  AST_TIMEOUT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_hit |=> cmd_err); // R8
  AST_SAMPLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sample_fire |-> busy && !cmd_done && !cmd_err); // R8
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready != busy); // R11
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_done && cmd_err)); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done); // R11
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(ctl_word[15:0])); // R11
  AST_BAD_OP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == 2'd3 |=> cmd_err); // R10
endmodule

bind phy_ctlport_master phy_ctlport_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .busy(busy), .cmd_done(cmd_done), .cmd_err(cmd_err),
  .ctl_word(ctl_word), .sample_fire(sample_fire), .timeout_hit(timeout_hit)
);

// File: tb/phy_ctlport_master_test.sv
module phy_ctlport_master_test;
  localparam int P = 4;
  localparam int L = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [15:0] cmd_arg = 16'h0;
  logic        pwr_down = 1'b0;
  logic        cmd_ready, busy, cmd_done, cmd_err;
  logic [15:0] rd_data;
  logic [20:0] ctl_word;
  logic [18:0] stat_word;

  int          checks = 0;
  int          errors = 0;
  int          ack_mode = 0;
  logic [15:0] rdval = 16'h0;
  logic [2:0]  dly = 3'b0;
  logic        ack;
  logic [3:0]  stb;

  always #5 clk = ~clk;

  phy_ctlport_master #(.POLL_CYCLES(P), .RETRY_LIMIT(L)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_arg(cmd_arg), .pwr_down(pwr_down), .busy(busy),
    .cmd_done(cmd_done), .cmd_err(cmd_err), .rd_data(rd_data),
    .ctl_word(ctl_word), .stat_word(stat_word)
  );

  // PHY acknowledge model
  assign stb = ctl_word[19:16];
  always @(posedge clk) dly <= {dly[1:0], |stb};
  always_comb begin
    case (ack_mode)
      0: ack = |stb;
      1: ack = 1'b0;
      2: ack = 1'b1;
      3: ack = stb[0] | stb[1] | stb[3];
      default: ack = dly[2];
    endcase
  end
  assign stat_word = {ack, 2'b00, stb[3] ? rdval : 16'h0BAD};

  // strobe edge log, entries {level, strobe index}
  logic [2:0] ev [0:15];
  int         ev_n = 0;
  logic [3:0] prev = 4'b0;
  always @(negedge clk) begin
    for (int i = 0; i < 4; i++)
      if (stb[i] !== prev[i]) begin
        if (ev_n < 16) ev[ev_n] = {stb[i], 2'(i)};
        ev_n++;
      end
    prev = stb;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  int   n_cyc, max_on;
  bit   got_done, got_err, ready_bad, pulse_long;
  logic [3:0] first_stb;

  task automatic do_cmd(input logic [1:0] op, input logic [15:0] arg);
    @(negedge clk); #1;
    ev_n = 0; got_done = 0; got_err = 0; ready_bad = 0; pulse_long = 0; max_on = 0;
    cmd_op = op; cmd_arg = arg; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    first_stb = stb;
    n_cyc = 1;
    while (!cmd_done && !cmd_err && n_cyc < 300) begin
      if (busy && cmd_ready) ready_bad = 1;
      if ($countones(stb) > max_on) max_on = $countones(stb);
      @(negedge clk);
      n_cyc++;
    end
    got_done = cmd_done; got_err = cmd_err;
    @(negedge clk);
    if (cmd_done || cmd_err) pulse_long = 1;
  endtask

  task automatic chk_ev(input int n, input logic [2:0] e0, input logic [2:0] e1,
                        input logic [2:0] e2, input logic [2:0] e3, input string req);
    logic [2:0] exp [0:3];
    exp[0] = e0; exp[1] = e1; exp[2] = e2; exp[3] = e3;
    chk(ev_n == n, req, "strobe edge count", ev_n, n);
    for (int i = 0; i < n && i < ev_n; i++)
      chk(ev[i] == exp[i], req, "strobe edge", int'(ev[i]), int'(exp[i]));
  endtask

  task automatic t_reset;
    chk(ctl_word[19:0] == 20'h0, "R1", "ctl after reset", int'(ctl_word[19:0]), 0);
    chk(!busy && cmd_ready && !cmd_done && !cmd_err, "R1", "flags after reset",
        {busy, cmd_ready, cmd_done, cmd_err}, 4'b0100);
    pwr_down = 1'b1; #1;
    chk(ctl_word[20] == 1'b1, "R2", "power-down bit high", int'(ctl_word[20]), 1);
    pwr_down = 1'b0; #1;
    chk(ctl_word[20] == 1'b0, "R2", "power-down bit low", int'(ctl_word[20]), 0);
  endtask

  task automatic t_addr;
    ack_mode = 0;
    do_cmd(2'd0, 16'h2003);
    chk(got_done && !got_err && n_cyc == 5, "R4", "address done cycle", n_cyc, 5);
    chk(ctl_word[15:0] == 16'h2003, "R2", "data-in field", int'(ctl_word[15:0]), 16'h2003);
    chk_ev(2, 3'b100, 3'b000, 3'b0, 3'b0, "R4");
    chk(!ready_bad && !pulse_long, "R11", "ready/pulse", {ready_bad, pulse_long}, 0);
  endtask

  task automatic t_write;
    ack_mode = 0;
    do_cmd(2'd1, 16'h1234);
    chk(got_done && n_cyc == 9, "R5", "write done cycle", n_cyc, 9);
    chk_ev(4, 3'b101, 3'b001, 3'b110, 3'b010, "R5");
    chk(max_on <= 1, "R12", "strobes high at once", max_on, 1);
  endtask

  task automatic t_read;
    ack_mode = 0; rdval = 16'hA5C3;
    do_cmd(2'd2, 16'hFFFF);
    chk(got_done && n_cyc == 5, "R7", "read done cycle", n_cyc, 5);
    chk(rd_data == 16'hA5C3, "R3", "read data latched", int'(rd_data), 16'hA5C3);
    chk(ctl_word[15:0] == 16'h1234, "R7", "data-in kept", int'(ctl_word[15:0]), 16'h1234);
    chk_ev(2, 3'b111, 3'b011, 3'b0, 3'b0, "R7");
  endtask

  task automatic t_delay;
    ack_mode = 4;
    do_cmd(2'd0, 16'h0042);
    chk(got_done && n_cyc == 13, "R8", "poll spacing done cycle", n_cyc, 13);
  endtask

  task automatic t_self_reset;
    ack_mode = 3;
    do_cmd(2'd1, 16'h0001);
    chk(got_done && !got_err && n_cyc == 6, "R6", "self-reset done cycle", n_cyc, 6);
    chk_ev(3, 3'b101, 3'b001, 3'b110, 3'b0, "R6");
    chk(stb == 4'b0100, "R6", "write strobe held", int'(stb), 4);
    do_cmd(2'd0, 16'h7F3F);
    chk(first_stb == 4'b0000, "R6", "strobes cleared at accept", int'(first_stb), 0);
    chk(got_done, "R6", "next command completes", int'(got_done), 1);
  endtask

  task automatic t_timeout;
    ack_mode = 1;
    do_cmd(2'd0, 16'h0011);
    chk(got_err && !got_done && n_cyc == 2 + (L-1)*P + 1, "R8", "rise timeout cycle",
        n_cyc, 2 + (L-1)*P + 1);
    ack_mode = 2;
    do_cmd(2'd0, 16'h0022);
    chk(got_err && n_cyc == 4 + (L-1)*P + 1, "R8", "fall timeout cycle",
        n_cyc, 4 + (L-1)*P + 1);
    ack_mode = 1;
    @(negedge clk);
    chk(stb == 4'b0 && cmd_ready, "R9", "strobes low after error", int'(stb), 0);
  endtask

  task automatic t_bad_op;
    ack_mode = 0;
    do_cmd(2'd3, 16'hBEEF);
    chk(got_err && n_cyc == 1, "R10", "bad opcode error cycle", n_cyc, 1);
    chk(ev_n == 0 && ctl_word[15:0] == 16'h0022, "R10", "no strobe / data kept", ev_n, 0);
    chk(!pulse_long, "R11", "error pulse width", int'(pulse_long), 0);
  endtask

  bit finished = 0;
  initial begin
    #1000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_addr();
    t_write();
    t_read();
    t_delay();
    t_self_reset();
    t_timeout();
    t_bad_op();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule